// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Port

This block gives seven external pins a choice of roles. Each pin can raise an interrupt request in one of four ways: while it is held low, or after a rising edge, a falling edge, or any edge. Any pin can also serve as a general-purpose input or output. Every pin input passes through a synchronizer. The synchronized value of every pin can always be read back. Edges are caught in sticky flags that software clears by writing ones. Per-pin enables decide which of the seven request lines reach the interrupt controller.

Software uses a small register bus with a write strobe, an address, write data and combinational read data. The mode register holds one 2-bit field per pin. The direction, enable, output-data, pin-state and flag registers hold one bit per pin, with pin i at bit i. Nothing changes mode or direction on its own. After reset every pin is an input, no interrupt is enabled and no flag is set.

Top module: `irq_pin_port`

## Requirements
- R1: After reset the mode (address 0), direction (address 1), enable (address 2), output-data (address 3) and flag (address 5) registers read 0. `pinOe` is 0 and `irqReq` is 0, so every pin is a general-purpose input.
- R2: Address 4 returns the pin inputs after a two-stage synchronizer. A pin change applied before clock edge k shows up after edge k+1. The synchronizer stages reset to 1.
- R3: The mode of pin i sits in bits [2i+1:2i] of address 0, which reads back as written. Code 00 selects level sensing, 01 rising edge, 10 falling edge and 11 both edges.
- R4: In rising mode the pin's flag is set by a low-to-high change of the synchronized pin and not by a high-to-low change.
- R5: In falling mode the pin's flag is set by a high-to-low change and not by a low-to-high change.
- R6: In both-edges mode the pin's flag is set by a change in either direction.
- R7: In level mode `irqReq[i]` is 1 exactly while the synchronized pin is low and enable bit i is 1. No flag is set in this mode.
- R8: In the edge modes `irqReq[i]` equals flag bit i ANDed with enable bit i. A cleared enable blocks the request, but the flag is still set.
- R9: Writing address 5 clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged. No flag drops without such a write.
- R10: When an edge event and a clearing write hit the same flag on the same clock edge, the flag ends up set.
- R11: `pinOe[i]` follows direction bit i (1 means output) and `pinOut[i]` follows output-data bit i. Each takes the value written one clock after the write.
- R12: Addresses 6 and 7 read 0. A write to address 4 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 2*NUM_PINS | Write data |
| regRdData | output | 2*NUM_PINS | Combinational read data for regAddr |
| pinIn | input | NUM_PINS | Asynchronous pin inputs |
| pinOut | output | NUM_PINS | Value driven on pins set as outputs |
| pinOe | output | NUM_PINS | Output enable per pin |
| irqReq | output | NUM_PINS | Interrupt request per pin |

## Verification
The bench drives edges of both polarities into pins in all four modes at the same time. A mode decoder with swapped codes or misplaced field bits would set the wrong flags. It reads the pin-state register one and two cycles after a pin change, so a synchronizer one stage too short or too long shows the new value in the wrong cycle. It times a clearing write to land on the same edge as a new event, which catches a design that lets the clear win. Writes of zero to the flag register, a cleared enable bit and a write to the read-only address all have to leave the flags and requests unchanged.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

  localparam int ADDR_MODE = 0;
  localparam int ADDR_DIR  = 1;
  localparam int ADDR_IEN  = 2;
  localparam int ADDR_OUT  = 3;
  localparam int ADDR_PINS = 4;
  localparam int ADDR_FLAG = 5;

  localparam logic [1:0] SENSE_LEVEL = 2'b00;
  localparam logic [1:0] SENSE_RISE  = 2'b01;
  localparam logic [1:0] SENSE_FALL  = 2'b10;
  localparam logic [1:0] SENSE_BOTH  = 2'b11;

  typedef struct packed {
    logic wrMode;
    logic wrDir;
    logic wrIen;
    logic wrOut;
    logic clrFlag;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_MODE,
    RD_DIR,
    RD_IEN,
    RD_OUT,
    RD_PINS,
    RD_FLAG,
    RD_NONE
  } rdsel_t;

endpackage

// File: rtl/irqp_control.sv
module irqp_control
  import irqp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe,
  output rdsel_t            rdSel
);

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      strobe.wrMode  = (regAddr == ADDR_W'(ADDR_MODE));
      strobe.wrDir   = (regAddr == ADDR_W'(ADDR_DIR));
      strobe.wrIen   = (regAddr == ADDR_W'(ADDR_IEN));
      strobe.wrOut   = (regAddr == ADDR_W'(ADDR_OUT));
      strobe.clrFlag = (regAddr == ADDR_W'(ADDR_FLAG));
    end
  end

  always_comb begin
    if (regAddr == ADDR_W'(ADDR_MODE))      rdSel = RD_MODE;
    else if (regAddr == ADDR_W'(ADDR_DIR))  rdSel = RD_DIR;
    else if (regAddr == ADDR_W'(ADDR_IEN))  rdSel = RD_IEN;
    else if (regAddr == ADDR_W'(ADDR_OUT))  rdSel = RD_OUT;
    else if (regAddr == ADDR_W'(ADDR_PINS)) rdSel = RD_PINS;
    else if (regAddr == ADDR_W'(ADDR_FLAG)) rdSel = RD_FLAG;
    else                                    rdSel = RD_NONE;
  end

endmodule

// File: rtl/irqp_datapath.sv
module irqp_datapath
  import irqp_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  rdsel_t              rdSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] irqReq
);

  localparam int PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinNow;
  logic [NUM_PINS-1:0] prevQ;
  logic [DATA_W-1:0]   modeQ;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] ienQ;
  logic [NUM_PINS-1:0] outQ;
  logic [NUM_PINS-1:0] flagQ;
  logic [NUM_PINS-1:0] hitEvt;
  logic [NUM_PINS-1:0] clrMask;

  // synchronizer chain, idle-high reset so no edge is seen on release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '1;
      prevQ <= '1;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      dirQ  <= '0;
      ienQ  <= '0;
      outQ  <= '0;
    end else begin
      if (strobe.wrMode) modeQ <= wrData;
      if (strobe.wrDir)  dirQ  <= wrData[NUM_PINS-1:0];
      if (strobe.wrIen)  ienQ  <= wrData[NUM_PINS-1:0];
      if (strobe.wrOut)  outQ  <= wrData[NUM_PINS-1:0];
    end
  end

  // per-pin sensing and request
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] sense;
    logic       rise;
    logic       fall;
    assign sense = modeQ[2*i+1 -: 2];
    assign rise  = pinNow[i] & ~prevQ[i];
    assign fall  = ~pinNow[i] & prevQ[i];

    always_comb begin
      unique case (sense)
        SENSE_RISE: hitEvt[i] = rise;
        SENSE_FALL: hitEvt[i] = fall;
        SENSE_BOTH: hitEvt[i] = rise | fall;
        default:    hitEvt[i] = 1'b0;
      endcase
    end

    assign irqReq[i] = ienQ[i] & ((sense == SENSE_LEVEL) ? ~pinNow[i] : flagQ[i]);
  end

  // write-one-to-clear flags; a new event outranks the clear
  assign clrMask = strobe.clrFlag ? wrData[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrMask) | hitEvt;
  end

  assign pinOut = outQ;
  assign pinOe  = dirQ;

  always_comb begin
    unique case (rdSel)
      RD_MODE: rdData = modeQ;
      RD_DIR:  rdData = {{PAD_W{1'b0}}, dirQ};
      RD_IEN:  rdData = {{PAD_W{1'b0}}, ienQ};
      RD_OUT:  rdData = {{PAD_W{1'b0}}, outQ};
      RD_PINS: rdData = {{PAD_W{1'b0}}, pinNow};
      RD_FLAG: rdData = {{PAD_W{1'b0}}, flagQ};
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_pin_port.sv
module irq_pin_port
  import irqp_pkg::*;
#(
  parameter  int NUM_PINS    = 7,
  parameter  int ADDR_W      = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int DATA_W      = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] irqReq
);

  strobe_t strobe;
  rdsel_t  rdSel;

  irqp_control #(.ADDR_W(ADDR_W)) u_ctl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  irqp_datapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_W      (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wrData (regWrData),
    .pinIn  (pinIn),
    .rdData (regRdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqReq (irqReq)
  );

endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int NUM_PINS = 7,
  parameter int ADDR_W   = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [NUM_PINS-1:0] wrLow,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] irqReq,
  input logic [NUM_PINS-1:0] flagQ,
  input logic [NUM_PINS-1:0] ienQ
);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (pinOe == '0 && irqReq == '0 && flagQ == '0));

  assert_dir_drives_oe_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(1)) |=> (pinOe == $past(wrLow)));

  assert_data_drives_pin_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(3)) |=> (pinOut == $past(wrLow)));

  assert_no_req_when_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~ienQ) == '0);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(5)) |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

endmodule

bind irq_pin_port irqp_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .wrLow   (regWrData[NUM_PINS-1:0]),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irqReq  (irqReq),
  .flagQ   (u_dp.flagQ),
  .ienQ    (u_dp.ienQ)
);

// File: tb/test_irq_pin_port.sv
module test_irq_pin_port;

  localparam int N  = 7;
  localparam int AW = 3;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [N-1:0]  pinIn = '1;
  logic [N-1:0]  pinOut;
  logic [N-1:0]  pinOe;
  logic [N-1:0]  irqReq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // scoreboard queues: kind 0 = register read, 1 = irqReq, 2 = pinOe, 3 = pinOut
  int    qKind[$];
  int    qExp[$];
  string qTag[$];
  event  monEv;

  always #4 clk = ~clk;

  irq_pin_port #(.NUM_PINS(N), .ADDR_W(AW)) i_irq_pin_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqReq(irqReq)
  );

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      int kind, expv, act;
      string tag;
      @(monEv);
      #1;
      while (qKind.size() > 0) begin
        kind = qKind.pop_front();
        expv = qExp.pop_front();
        tag  = qTag.pop_front();
        case (kind)
          0: act = int'(regRdData);
          1: act = int'(irqReq);
          2: act = int'(pinOe);
          default: act = int'(pinOut);
        endcase
        compared++;
        if (act != expv) begin
          mismatched++;
          $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", tag, kind, regAddr, act, expv);
        end
      end
    end
  end

  task automatic expectItem(input int kind, input int addr, input int expv, input string tag);
    @(negedge clk);
    regAddr = AW'(addr);
    qKind.push_back(kind);
    qExp.push_back(expv);
    qTag.push_back(tag);
    ->monEv;
    #2;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regWrEn   = 1'b1;
    regAddr   = AW'(addr);
    regWrData = DW'(data);
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPins(input int v);
    @(negedge clk);
    pinIn = N'(v);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectItem(0, 0, 0, "R1 mode");
    expectItem(0, 1, 0, "R1 dir");
    expectItem(0, 2, 0, "R1 ien");
    expectItem(0, 3, 0, "R1 out");
    expectItem(0, 5, 0, "R1 flag");
    expectItem(1, 0, 0, "R1 irqReq");
    expectItem(2, 0, 0, "R1 pinOe");

    // R2 synchronizer latency
    expectItem(0, 4, 'h7F, "R2 idle pins");
    setPins('h55);
    expectItem(0, 4, 'h7F, "R2 one edge later");
    expectItem(0, 4, 'h55, "R2 two edges later");
    setPins('h7F);
    idle(4);
    expectItem(0, 5, 0, "R7 level mode sets no flag");

    // R3 mode fields: pin0 rise, pin1 fall, pin2 both, pin3 level
    wr(0, 'h39);
    expectItem(0, 0, 'h39, "R3 mode readback");
    wr(2, 'h0F);

    // falling changes on pins 0..2
    setPins('h78);
    idle(4);
    expectItem(0, 5, 'h06, "R5 R6 falling edge flags, R4 rise ignores fall");
    expectItem(1, 0, 'h06, "R8 requests from flags");

    // R9 writes of zero change nothing, ones clear
    wr(5, 'h00);
    expectItem(0, 5, 'h06, "R9 zero write no effect");
    wr(5, 'h06);
    expectItem(0, 5, 'h00, "R9 ones clear");
    expectItem(1, 0, 'h00, "R9 requests drop");

    // rising changes on pins 0..2
    setPins('h7F);
    idle(4);
    expectItem(0, 5, 'h05, "R4 R6 rising edge flags");
    expectItem(1, 0, 'h05, "R8 requests");

    // R8 enable gating
    wr(2, 'h00);
    expectItem(1, 0, 'h00, "R8 disabled blocks request");
    expectItem(0, 5, 'h05, "R8 flags kept while disabled");
    wr(2, 'h0F);
    expectItem(1, 0, 'h05, "R8 re-enabled");
    wr(5, 'h7F);
    expectItem(0, 5, 'h00, "R9 clear all");

    // R7 level sensing on pin3
    setPins('h77);
    idle(3);
    expectItem(1, 0, 'h08, "R7 level low requests");
    expectItem(0, 5, 'h00, "R7 level no flag");
    setPins('h7F);
    idle(3);
    expectItem(1, 0, 'h00, "R7 level high releases");

    // R10 edge and clear on the same clock edge
    setPins('h7E);
    idle(4);
    expectItem(0, 5, 'h00, "R4 fall ignored in rise mode");
    @(negedge clk);
    pinIn = 'h7F;
    @(posedge clk);
    @(posedge clk);
    wr(5, 'h01);
    expectItem(0, 5, 'h01, "R10 edge beats clear");
    wr(5, 'h01);
    expectItem(0, 5, 'h00, "R10 later clear works");

    // R11 GPIO output
    wr(1, 'h41);
    wr(3, 'h01);
    expectItem(2, 0, 'h41, "R11 pinOe");
    expectItem(3, 0, 'h01, "R11 pinOut");
    expectItem(0, 1, 'h41, "R11 dir readback");

    // R12 unused addresses and read-only pin register
    expectItem(0, 6, 0, "R12 addr 6");
    expectItem(0, 7, 0, "R12 addr 7");
    wr(5, 'h7F);
    wr(4, 'h00);
    expectItem(0, 4, 'h7F, "R12 pin state unchanged");
    expectItem(0, 5, 'h00, "R12 flags unchanged");
    expectItem(0, 0, 'h39, "R12 mode unchanged");

    idle(2);
    finished = 1;
    summary();
  end

endmodule